// File: doc/BRIEF.md
# Programmable Half-Duty Clock Divider

This block derives a slower clock from an input clock. An 8-bit divide selector `div_sel` sets the ratio N = 1 + `div_sel`, so the output frequency is the input frequency divided by N, from 1 to 256. The output is high for exactly half of every output period, whether N is even or odd.

One toggle flop starts each output period. The end of the high phase is marked by a second toggle flop. For even N that flop is clocked on the input rising edge. For odd N a third toggle flop, clocked on the input falling edge, marks it instead. The output is the XOR of all three. When the selector is zero, the input clock is routed straight to the output.

A new selector value is held back until the current output period has completed. Software or a neighbouring block may therefore change it at any time without producing a shortened pulse. Reset is synchronous and active high. While it is held, the output stays low.

Top module: `clkdiv50_top`

## Requirements
- R1: While `rst` is high for at least one full input clock cycle, `clk_out` is low during both clock phases.
- R2: With `div_sel` = P in 1..255, `clk_out` has a period of exactly N = P+1 input clock periods.
- R3: With `div_sel` odd (N even), `clk_out` is high for exactly N/2 input periods, and it falls on an input rising edge.
- R4: With `div_sel` even and nonzero (N odd), `clk_out` is high for exactly N/2 input periods (a whole number of periods plus one half), and it falls on an input falling edge.
- R5: With `div_sel` = 0, `clk_out` follows `clk_in`: its period is one input period and it is high for half of it.
- R6: A change of `div_sel` takes effect only at the next output period boundary. The period already under way completes with its old length and high time, and the next period uses the new value.
- R7: Every rising edge of `clk_out` coincides with a rising edge of `clk_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| div_sel | input | 8 | Divide selector P; ratio N = P + 1 |
| clk_out | output | 1 | Divided clock with 50% duty cycle |

## Verification
The hardest case to reach is a selector change that lands partway through an output period. The bench sets up a long ratio and waits for an output rising edge. Two input cycles later it switches to a shorter ratio. It then measures the high time and period still under way, followed by the period after it, and checks each against its own ratio. The transitions into and out of pass-through are reached by moving the selector through zero and on to nonzero ratios. The phase of every output edge is checked against the input clock.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  localparam int DEF_SEL_W = 8;

  // Divider operating mode, derived from the captured selector
  typedef enum logic [1:0] {
    DM_PASS = 2'd0,  // selector zero: input routed to output
    DM_EVEN = 2'd1,  // N even: high phase ends on a rising edge
    DM_ODD  = 2'd2   // N odd: high phase ends on a falling edge
  } div_mode_e;

  function automatic div_mode_e mode_of(input logic sel_zero, input logic sel_lsb);
    if (sel_zero)     return DM_PASS;
    else if (sel_lsb) return DM_EVEN;
    else              return DM_ODD;
  endfunction

endpackage

// File: rtl/clkdiv_period_ctr.sv
module clkdiv_period_ctr #(
  parameter int SEL_W = clkdiv_pkg::DEF_SEL_W
) (
  input  logic             clk_in,
  input  logic             rst,
  input  logic [SEL_W-1:0] div_sel,
  output logic [SEL_W-1:0] cnt_q,
  output logic [SEL_W-1:0] sel_act_q,
  output logic             byp_q,
  output logic             tog_rise_q
);

  logic wrap;
  logic sel_in_zero;

  assign wrap        = (cnt_q == sel_act_q);
  assign sel_in_zero = (div_sel == '0);

  // Counter runs 0..P; selector captured only at the period boundary
  always_ff @(posedge clk_in) begin
    if (rst) begin
      cnt_q      <= '0;
      sel_act_q  <= '0;
      byp_q      <= 1'b0;
      tog_rise_q <= 1'b0;
    end else if (wrap) begin
      cnt_q     <= '0;
      sel_act_q <= div_sel;
      byp_q     <= sel_in_zero;
      if (!sel_in_zero)
        tog_rise_q <= ~tog_rise_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/clkdiv_fall_gen.sv
module clkdiv_fall_gen #(
  parameter int SEL_W = clkdiv_pkg::DEF_SEL_W
) (
  input  logic             clk_in,
  input  logic             rst,
  input  logic [SEL_W-1:0] cnt_q,
  input  logic [SEL_W-1:0] sel_act_q,
  output logic             tog_even_q,
  output logic             tog_odd_q
);
  import clkdiv_pkg::*;

  div_mode_e        mode;
  logic [SEL_W-1:0] mid;
  logic             at_mid;

  assign mode   = mode_of(sel_act_q == '0, sel_act_q[0]);
  assign mid    = sel_act_q >> 1;  // N/2-1 for even N, (N-1)/2 for odd N
  assign at_mid = (cnt_q == mid);

  // Even N: end the high phase on the rising edge that reaches N/2
  always_ff @(posedge clk_in) begin
    if (rst)
      tog_even_q <= 1'b0;
    else if (mode == DM_EVEN && at_mid)
      tog_even_q <= ~tog_even_q;
  end

  // Odd N: end the high phase on the falling edge inside count (N-1)/2
  always_ff @(negedge clk_in) begin
    if (rst)
      tog_odd_q <= 1'b0;
    else if (mode == DM_ODD && at_mid)
      tog_odd_q <= ~tog_odd_q;
  end

endmodule

// File: rtl/clkdiv50_top.sv
module clkdiv50_top #(
  parameter int SEL_W = clkdiv_pkg::DEF_SEL_W
) (
  input  logic             clk_in,
  input  logic             rst,
  input  logic [SEL_W-1:0] div_sel,
  output logic             clk_out
);

  logic [SEL_W-1:0] cnt_q;
  logic [SEL_W-1:0] sel_act_q;
  logic             byp_q;
  logic             tog_rise_q;
  logic             tog_even_q;
  logic             tog_odd_q;
  logic             div_clk;

  clkdiv_period_ctr #(.SEL_W(SEL_W)) u_ctr (
    .clk_in     (clk_in),
    .rst        (rst),
    .div_sel    (div_sel),
    .cnt_q      (cnt_q),
    .sel_act_q  (sel_act_q),
    .byp_q      (byp_q),
    .tog_rise_q (tog_rise_q)
  );

  clkdiv_fall_gen #(.SEL_W(SEL_W)) u_fall (
    .clk_in     (clk_in),
    .rst        (rst),
    .cnt_q      (cnt_q),
    .sel_act_q  (sel_act_q),
    .tog_even_q (tog_even_q),
    .tog_odd_q  (tog_odd_q)
  );

  // Each period flips the rise flop once and exactly one fall flop once
  assign div_clk = tog_rise_q ^ tog_even_q ^ tog_odd_q;
  assign clk_out = byp_q ? clk_in : div_clk;

endmodule

// File: rtl/clkdiv50_chk.sv
module clkdiv50_chk #(
  parameter int SEL_W = 8
) (
  input logic             clk_in,
  input logic             rst,
  input logic [SEL_W-1:0] cnt_q,
  input logic [SEL_W-1:0] sel_act_q,
  input logic             byp_q,
  input logic             tog_rise_q,
  input logic             tog_even_q
);

  logic past_ok;
  always_ff @(posedge clk_in) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  AST_RST_CLEAR: assert property (@(posedge clk_in)
    rst |=> (cnt_q == '0 && sel_act_q == '0 && !byp_q)); // R1

  AST_CNT_BOUND: assert property (@(posedge clk_in) disable iff (rst)
    past_ok |-> cnt_q <= sel_act_q); // R2

  AST_SEL_HOLD: assert property (@(posedge clk_in) disable iff (rst)
    (past_ok && sel_act_q != $past(sel_act_q)) |-> cnt_q == '0); // R6

  AST_RISE_AT_START: assert property (@(posedge clk_in) disable iff (rst)
    (past_ok && tog_rise_q != $past(tog_rise_q)) |-> (cnt_q == '0 && !byp_q)); // R7

  AST_ODD_RISE_QUIET: assert property (@(posedge clk_in) disable iff (rst)
    (past_ok && !sel_act_q[0] && sel_act_q == $past(sel_act_q)) |-> $stable(tog_even_q)); // R4

  AST_PASS_FROZEN: assert property (@(posedge clk_in) disable iff (rst)
    (past_ok && byp_q && $past(byp_q)) |-> ($stable(tog_rise_q) && $stable(tog_even_q))); // R5

endmodule

bind clkdiv50_top clkdiv50_chk #(.SEL_W(SEL_W)) u_chk (
  .clk_in     (clk_in),
  .rst        (rst),
  .cnt_q      (cnt_q),
  .sel_act_q  (sel_act_q),
  .byp_q      (byp_q),
  .tog_rise_q (tog_rise_q),
  .tog_even_q (tog_even_q)
);

// File: tb/sim_clkdiv50_top.sv
`timescale 1ps/1ps
module sim_clkdiv50_top;

  localparam longint HALF = 2500;   // 200 MHz input clock
  localparam longint PER  = 2 * HALF;

  logic       clk_in = 1'b0;
  logic       rst    = 1'b1;
  logic [7:0] div_sel = 8'd0;
  logic       clk_out;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;

  clkdiv50_top #(.SEL_W(8)) u0 (
    .clk_in  (clk_in),
    .rst     (rst),
    .div_sel (div_sel),
    .clk_out (clk_out)
  );

  always #(HALF) clk_in = ~clk_in;

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk_in) begin
    cycles++;
    if (cycles > 100000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles, expected completion", cycles);
      summary();
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // R1: output low through a held reset, sampled in both phases
  task automatic test_reset_low();
    @(negedge clk_in);
    rst = 1'b1;
    repeat (2) @(negedge clk_in);
    #1 check(clk_out == 1'b0, "R1", "low phase", clk_out, 0);
    @(posedge clk_in);
    #1 check(clk_out == 1'b0, "R1", "high phase", clk_out, 0);
    @(negedge clk_in);
    rst = 1'b0;
  endtask

  // R2..R5, R7: measure several periods at one ratio
  task automatic run_ratio(input int p, input int periods);
    longint n, t0, t1, t2;
    string  rh;
    n = p + 1;
    rh = (p == 0) ? "R5" : ((p % 2) == 1) ? "R3" : "R4";
    @(negedge clk_in);
    div_sel = p[7:0];
    repeat (2) @(posedge clk_out);
    t0 = $time;
    for (int k = 0; k < periods; k++) begin
      check((t0 % PER) == HALF, "R7", "rise phase", t0 % PER, HALF);
      @(negedge clk_out); t1 = $time;
      @(posedge clk_out); t2 = $time;
      check((t1 - t0) == n * HALF, rh, "high time", t1 - t0, n * HALF);
      if (p != 0 && (p % 2) == 0)
        check((t1 % PER) == 0, "R4", "fall on input falling edge", t1 % PER, 0);
      if (p % 2 == 1)
        check((t1 % PER) == HALF, "R3", "fall on input rising edge", t1 % PER, HALF);
      check((t2 - t0) == n * PER, (p == 0) ? "R5" : "R2", "period", t2 - t0, n * PER);
      t0 = t2;
    end
  endtask

  // R6: change ratio two cycles into a period
  task automatic test_mid_change();
    longint t0, t1, t2, t3, t4;
    @(negedge clk_in);
    div_sel = 8'd7;
    repeat (2) @(posedge clk_out);
    t0 = $time;
    repeat (2) @(negedge clk_in);
    div_sel = 8'd3;
    @(negedge clk_out); t1 = $time;
    @(posedge clk_out); t2 = $time;
    @(negedge clk_out); t3 = $time;
    @(posedge clk_out); t4 = $time;
    check((t1 - t0) == 8 * HALF, "R6", "old high time kept", t1 - t0, 8 * HALF);
    check((t2 - t0) == 8 * PER,  "R6", "old period kept",    t2 - t0, 8 * PER);
    check((t3 - t2) == 4 * HALF, "R6", "new high time",      t3 - t2, 4 * HALF);
    check((t4 - t2) == 4 * PER,  "R6", "new period",         t4 - t2, 4 * PER);
  endtask

  initial begin
    repeat (3) @(negedge clk_in);
    #1 check(clk_out == 1'b0, "R1", "initial reset", clk_out, 0);
    @(negedge clk_in);
    rst = 1'b0;
    run_ratio(0, 3);
    run_ratio(1, 3);
    run_ratio(2, 3);
    run_ratio(3, 3);
    run_ratio(7, 3);
    run_ratio(255, 2);
    test_mid_change();
    run_ratio(0, 2);
    run_ratio(4, 2);
    test_reset_low();
    run_ratio(5, 2);
    summary();
  end

endmodule